// File: doc/BRIEF.md
# Decoded Micro-op Cache

This block keeps the micro-op groups that an instruction decoder produces so that a repeated fetch can skip decoding. Each group is stored under the fetch address that produced it, in a direct-mapped array of lines. A line holds a tag, a valid flag, a micro-op count and a fixed number of micro-op slots. Every fetch address is looked up in the cache first. One cycle later the block reports hit or miss. On a hit it returns the stored micro-ops and drops the decoder-enable output, so the fetch and decode path can idle. On a miss it raises decoder-enable again in that same response cycle.

Filling is unconditional. Every group the decoder emits is written into the line its address selects, provided the group fits in a line. There is only one way per set, so the new group replaces whatever the line held before. The block must only hold groups whose instruction bytes are still present in a separate instruction cache. That cache reports each of its evictions on an invalidate port, and the block drops the matching line.

The address is split into an index, taken from the low `log2(SETS)` bits, and a tag, taken from the remaining upper bits. The default geometry is 256 sets of 6 slots, which gives 1536 micro-ops.

Top module: `uop_cache`

## Requirements
- R1: While reset is held and after it is released, `resp_valid_o`=0, `hit_o`=0, `uop_count_o`=0, `uops_o`=0 and `decode_en_o`=1. Every line is empty, so every lookup made before the first fill misses.
- R2: `resp_valid_o` is 1 in the cycle after a cycle with `fetch_valid_i`=1, and 0 in the cycle after a cycle with `fetch_valid_i`=0. `hit_o` is 0 whenever `resp_valid_o` is 0.
- R3: A lookup hits when the line at index `addr[IDX_W-1:0]` is valid and its stored tag equals `addr[ADDR_W-1:IDX_W]`.
  - On a hit, `uop_count_o` is the stored count and slot k of `uops_o` (bits `k*UOP_W +: UOP_W`) is the stored micro-op k for every k < count. Slots with k >= count read 0.
  - On a miss, or with no response, `uop_count_o` and `uops_o` are 0.
- R4: `decode_en_o` goes to 0 in a response cycle with a hit and to 1 in a response cycle with a miss. In cycles without a response it keeps its previous value.
- R5: Every decoder group with `dec_valid_i`=1 and a count from 1 to SLOTS is written without any filtering. The write goes to the set and tag of `dec_addr_i`, with slot k taken from `dec_uops_i[k*UOP_W +: UOP_W]`. The written line is visible to a lookup in the next cycle.
- R6: A decoder group with a count of 0 or a count above SLOTS is not stored, and the line at its index is left unchanged.
- R7: A fill into a set whose line is already valid replaces that line. The previous address then misses and the new address hits.
- R8: An invalidate whose address matches a valid line's index and tag clears that line. An invalidate whose tag differs from the stored tag leaves the line intact.
- R9: When an invalidate and a stored fill target the same set in the same cycle, the line ends up invalid, whatever the invalidate's tag is.
- R10: A lookup presented in the same cycle as a fill or an invalidate of its set sees the line contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid_i | input | 1 | A lookup is requested this cycle |
| fetch_addr_i | input | ADDR_W | Fetch address to look up |
| dec_valid_i | input | 1 | Decoder presents a group this cycle |
| dec_addr_i | input | ADDR_W | Fetch address the decoder group belongs to |
| dec_count_i | input | clog2(2*SLOTS+1) | Number of micro-ops in the group |
| dec_uops_i | input | SLOTS*UOP_W | Micro-ops of the group, slot k at k*UOP_W |
| inval_valid_i | input | 1 | Instruction cache eviction notice this cycle |
| inval_addr_i | input | ADDR_W | Evicted fetch address |
| resp_valid_o | output | 1 | Lookup response present |
| hit_o | output | 1 | Lookup hit |
| uop_count_o | output | clog2(SLOTS+1) | Micro-op count on a hit, else 0 |
| uops_o | output | SLOTS*UOP_W | Cached micro-ops, unused slots 0 |
| decode_en_o | output | 1 | Fetch and decode path enable, 0 while hits are served |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. A lookup's hit, count, micro-ops and decoder gate appear after the edge that captures `fetch_valid_i`. A fill or an invalidate changes what a lookup sees only from the following edge on. The bench drives its inputs shortly after a rising edge and samples the outputs shortly after the next rising edge. It computes its expected values from a model whose state it updates only after that sample. Because of this, a same-cycle lookup is predicted against the line contents from before the update, and every later lookup against the contents after it.

// File: rtl/uc_pkg.sv
package uc_pkg;

  // State of the front-end gate driven by the most recent lookup.
  typedef enum logic {
    GATE_OPEN = 1'b0,
    GATE_SHUT = 1'b1
  } uc_gate_e;

endpackage

// File: rtl/uc_rst_sync.sv
module uc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/uc_tag_store.sv
module uc_tag_store #(
  parameter int SETS  = 256,
  parameter int IDX_W = 8,
  parameter int TAG_W = 16,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  output logic [CNT_W-1:0] lk_cnt_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic             inv_en_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  input  logic [TAG_W-1:0] inv_tag_i
);

  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  valid_d;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [CNT_W-1:0] cnt_q [SETS];
  logic             inv_match;
  logic             inv_collide;
  logic             inv_kill;

  // An eviction kills the line when its tag matches, or when a fill
  // lands in the same set this cycle (the safe outcome for inclusion).
  assign inv_match   = valid_q[inv_idx_i] && (tag_q[inv_idx_i] == inv_tag_i);
  assign inv_collide = wr_en_i && (wr_idx_i == inv_idx_i);
  assign inv_kill    = inv_en_i && (inv_match || inv_collide);

  always_comb begin
    valid_d = valid_q;
    if (wr_en_i) begin
      valid_d[wr_idx_i] = 1'b1;
    end
    if (inv_kill) begin
      valid_d[inv_idx_i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // Tag and count storage carries no reset; valid qualifies it.
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      cnt_q[wr_idx_i] <= wr_cnt_i;
    end
  end

  assign lk_hit_o = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  assign lk_cnt_o = cnt_q[lk_idx_i];

endmodule

// File: rtl/uc_data_store.sv
module uc_data_store #(
  parameter int SETS  = 256,
  parameter int IDX_W = 8,
  parameter int SLOTS = 6,
  parameter int UOP_W = 16,
  parameter int CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [CNT_W-1:0]       wr_cnt_i,
  input  logic [SLOTS*UOP_W-1:0] wr_uops_i,
  input  logic [IDX_W-1:0]       rd_idx_i,
  output logic [SLOTS*UOP_W-1:0] rd_uops_o
);

  // One array per slot; a slot past the group's count is not clocked.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [CNT_W-1:0] SLOT_ID = CNT_W'(s);
    logic [UOP_W-1:0] mem_q [SETS];
    logic             slot_we;

    assign slot_we = wr_en_i && (SLOT_ID < wr_cnt_i);

    always_ff @(posedge clk) begin
      if (slot_we) begin
        mem_q[wr_idx_i] <= wr_uops_i[s*UOP_W +: UOP_W];
      end
    end

    assign rd_uops_o[s*UOP_W +: UOP_W] = mem_q[rd_idx_i];
  end

endmodule

// File: rtl/uc_resp.sv
module uc_resp
  import uc_pkg::*;
#(
  parameter int SLOTS = 6,
  parameter int UOP_W = 16,
  parameter int CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_valid_i,
  input  logic                   lk_hit_i,
  input  logic [CNT_W-1:0]       lk_cnt_i,
  input  logic [SLOTS*UOP_W-1:0] lk_uops_i,
  output logic                   resp_valid_o,
  output logic                   hit_o,
  output logic [CNT_W-1:0]       uop_count_o,
  output logic [SLOTS*UOP_W-1:0] uops_o,
  output logic                   decode_en_o
);

  logic                   resp_valid_q, resp_valid_d;
  logic                   hit_q, hit_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [SLOTS*UOP_W-1:0] uops_q, uops_d;
  uc_gate_e               gate_q, gate_d;

  always_comb begin
    resp_valid_d = fetch_valid_i;
    hit_d        = fetch_valid_i && lk_hit_i;
    cnt_d        = hit_d ? lk_cnt_i : '0;
    gate_d       = gate_q;
    if (fetch_valid_i) begin
      gate_d = lk_hit_i ? GATE_SHUT : GATE_OPEN;
    end
  end

  // Slots at or past the stored count are forced to zero.
  for (genvar s = 0; s < SLOTS; s++) begin : g_mask
    localparam logic [CNT_W-1:0] SLOT_ID = CNT_W'(s);
    assign uops_d[s*UOP_W +: UOP_W] =
      (hit_d && (SLOT_ID < lk_cnt_i)) ? lk_uops_i[s*UOP_W +: UOP_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      hit_q        <= 1'b0;
      cnt_q        <= '0;
      uops_q       <= '0;
      gate_q       <= GATE_OPEN;
    end else begin
      resp_valid_q <= resp_valid_d;
      hit_q        <= hit_d;
      cnt_q        <= cnt_d;
      uops_q       <= uops_d;
      gate_q       <= gate_d;
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign hit_o        = hit_q;
  assign uop_count_o  = cnt_q;
  assign uops_o       = uops_q;
  assign decode_en_o  = (gate_q == GATE_OPEN);

endmodule

// File: rtl/uop_cache.sv
module uop_cache #(
  parameter  int SETS      = 256,
  parameter  int SLOTS     = 6,
  parameter  int UOP_W     = 16,
  parameter  int ADDR_W    = 24,
  localparam int IDX_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - IDX_W,
  localparam int LINE_CW   = $clog2(SLOTS + 1),
  localparam int DEC_CW    = $clog2(2 * SLOTS + 1),
  localparam int LINE_BITS = SLOTS * UOP_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_valid_i,
  input  logic [ADDR_W-1:0]    fetch_addr_i,
  input  logic                 dec_valid_i,
  input  logic [ADDR_W-1:0]    dec_addr_i,
  input  logic [DEC_CW-1:0]    dec_count_i,
  input  logic [LINE_BITS-1:0] dec_uops_i,
  input  logic                 inval_valid_i,
  input  logic [ADDR_W-1:0]    inval_addr_i,
  output logic                 resp_valid_o,
  output logic                 hit_o,
  output logic [LINE_CW-1:0]   uop_count_o,
  output logic [LINE_BITS-1:0] uops_o,
  output logic                 decode_en_o
);

  localparam logic [DEC_CW-1:0] MAX_CNT = DEC_CW'(SLOTS);

  logic                 rst_q_n;
  logic                 fill_ok;
  logic [LINE_CW-1:0]   fill_cnt;
  logic                 lk_hit;
  logic [LINE_CW-1:0]   lk_cnt;
  logic [LINE_BITS-1:0] lk_uops;

  uc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // Blind fill: any group that fits a line is written.
  assign fill_ok  = dec_valid_i && (dec_count_i != '0) && (dec_count_i <= MAX_CNT);
  assign fill_cnt = dec_count_i[LINE_CW-1:0];

  uc_tag_store #(
    .SETS  (SETS),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .CNT_W (LINE_CW)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .lk_idx_i  (fetch_addr_i[IDX_W-1:0]),
    .lk_tag_i  (fetch_addr_i[ADDR_W-1:IDX_W]),
    .lk_hit_o  (lk_hit),
    .lk_cnt_o  (lk_cnt),
    .wr_en_i   (fill_ok),
    .wr_idx_i  (dec_addr_i[IDX_W-1:0]),
    .wr_tag_i  (dec_addr_i[ADDR_W-1:IDX_W]),
    .wr_cnt_i  (fill_cnt),
    .inv_en_i  (inval_valid_i),
    .inv_idx_i (inval_addr_i[IDX_W-1:0]),
    .inv_tag_i (inval_addr_i[ADDR_W-1:IDX_W])
  );

  uc_data_store #(
    .SETS  (SETS),
    .IDX_W (IDX_W),
    .SLOTS (SLOTS),
    .UOP_W (UOP_W),
    .CNT_W (LINE_CW)
  ) u_data (
    .clk       (clk),
    .wr_en_i   (fill_ok),
    .wr_idx_i  (dec_addr_i[IDX_W-1:0]),
    .wr_cnt_i  (fill_cnt),
    .wr_uops_i (dec_uops_i),
    .rd_idx_i  (fetch_addr_i[IDX_W-1:0]),
    .rd_uops_o (lk_uops)
  );

  uc_resp #(
    .SLOTS (SLOTS),
    .UOP_W (UOP_W),
    .CNT_W (LINE_CW)
  ) u_resp (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .fetch_valid_i (fetch_valid_i),
    .lk_hit_i      (lk_hit),
    .lk_cnt_i      (lk_cnt),
    .lk_uops_i     (lk_uops),
    .resp_valid_o  (resp_valid_o),
    .hit_o         (hit_o),
    .uop_count_o   (uop_count_o),
    .uops_o        (uops_o),
    .decode_en_o   (decode_en_o)
  );

endmodule

// File: rtl/uop_cache_checker.sv
module uop_cache_checker #(
  parameter int SLOTS     = 6,
  parameter int LINE_CW   = 3,
  parameter int LINE_BITS = 96
) (
  input logic                 clk,
  input logic                 rst_q_n,
  input logic                 fetch_valid_i,
  input logic                 resp_valid_o,
  input logic                 hit_o,
  input logic [LINE_CW-1:0]   uop_count_o,
  input logic [LINE_BITS-1:0] uops_o,
  input logic                 decode_en_o
);

  localparam logic [LINE_CW-1:0] MAX_CNT = LINE_CW'(SLOTS);

  p_resp_follows_fetch_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    fetch_valid_i |=> resp_valid_o);

  p_no_resp_without_fetch_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !fetch_valid_i |=> !resp_valid_o);

  p_hit_needs_resp_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    hit_o |-> resp_valid_o);

  p_miss_is_empty_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !hit_o |-> (uop_count_o == '0) && (uops_o == '0));

  p_hit_count_range_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    hit_o |-> (uop_count_o != '0) && (uop_count_o <= MAX_CNT));

  p_hit_gates_decode_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (resp_valid_o && hit_o) |-> !decode_en_o);

  p_miss_opens_decode_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (resp_valid_o && !hit_o) |-> decode_en_o);

  p_gate_holds_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !resp_valid_o |-> $stable(decode_en_o));

endmodule

bind uop_cache uop_cache_checker #(
  .SLOTS     (SLOTS),
  .LINE_CW   (LINE_CW),
  .LINE_BITS (LINE_BITS)
) u_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .fetch_valid_i (fetch_valid_i),
  .resp_valid_o  (resp_valid_o),
  .hit_o         (hit_o),
  .uop_count_o   (uop_count_o),
  .uops_o        (uops_o),
  .decode_en_o   (decode_en_o)
);

// File: tb/uop_cache_bench.sv
`timescale 1ns/1ps
module uop_cache_bench;

  localparam int SETS   = 4;
  localparam int SLOTS  = 3;
  localparam int UOP_W  = 8;
  localparam int ADDR_W = 6;
  localparam int NADDR  = 1 << ADDR_W;
  localparam int LCW    = $clog2(SLOTS + 1);
  localparam int DCW    = $clog2(2 * SLOTS + 1);
  localparam int LB     = SLOTS * UOP_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              fetch_valid_i;
  logic [ADDR_W-1:0] fetch_addr_i;
  logic              dec_valid_i;
  logic [ADDR_W-1:0] dec_addr_i;
  logic [DCW-1:0]    dec_count_i;
  logic [LB-1:0]     dec_uops_i;
  logic              inval_valid_i;
  logic [ADDR_W-1:0] inval_addr_i;
  logic              resp_valid_o;
  logic              hit_o;
  logic [LCW-1:0]    uop_count_o;
  logic [LB-1:0]     uops_o;
  logic              decode_en_o;

  int checks   = 0;
  int failures = 0;

  // Reference model state.
  bit             m_v   [SETS];
  int             m_tag [SETS];
  int             m_cnt [SETS];
  logic [UOP_W-1:0] m_u [SETS][SLOTS];
  bit             m_shut;
  logic [31:0]    lfsr;

  always #4 clk = ~clk;

  uop_cache #(
    .SETS   (SETS),
    .SLOTS  (SLOTS),
    .UOP_W  (UOP_W),
    .ADDR_W (ADDR_W)
  ) u_uop_cache (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .dec_valid_i   (dec_valid_i),
    .dec_addr_i    (dec_addr_i),
    .dec_count_i   (dec_count_i),
    .dec_uops_i    (dec_uops_i),
    .inval_valid_i (inval_valid_i),
    .inval_addr_i  (inval_addr_i),
    .resp_valid_o  (resp_valid_o),
    .hit_o         (hit_o),
    .uop_count_o   (uop_count_o),
    .uops_o        (uops_o),
    .decode_en_o   (decode_en_o)
  );

  function automatic logic [UOP_W-1:0] uop_val(input int addr, input int k, input int gen);
    return UOP_W'(addr * 5 + k * 29 + gen * 3 + 1);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fetch_valid_i = 1'b0;
    fetch_addr_i  = '0;
    dec_valid_i   = 1'b0;
    dec_addr_i    = '0;
    dec_count_i   = '0;
    dec_uops_i    = '0;
    inval_valid_i = 1'b0;
    inval_addr_i  = '0;
  endtask

  // One cycle: drive, predict from the model, sample after the edge, update model.
  task automatic step(input bit fv, input int fa, input bit dv, input int da,
                      input int dc, input int gen, input bit iv, input int ia,
                      input string req);
    int            fi, di, ii;
    bit            e_hit, fill_ok, kill;
    int            e_cnt;
    logic [LB-1:0] e_uops;
    fetch_valid_i = fv;
    fetch_addr_i  = ADDR_W'(fa);
    dec_valid_i   = dv;
    dec_addr_i    = ADDR_W'(da);
    dec_count_i   = DCW'(dc);
    for (int k = 0; k < SLOTS; k++) dec_uops_i[k*UOP_W +: UOP_W] = uop_val(da, k, gen);
    inval_valid_i = iv;
    inval_addr_i  = ADDR_W'(ia);

    fi     = fa % SETS;
    e_hit  = fv && m_v[fi] && (m_tag[fi] == fa / SETS);
    e_cnt  = e_hit ? m_cnt[fi] : 0;
    e_uops = '0;
    for (int k = 0; k < SLOTS; k++)
      if (k < e_cnt) e_uops[k*UOP_W +: UOP_W] = m_u[fi][k];
    if (fv) m_shut = e_hit;

    @(posedge clk);
    #1;
    chk("R2", "resp_valid", 64'(resp_valid_o), 64'(fv));
    chk(req, "hit", 64'(hit_o), 64'(e_hit));
    chk(req, "count", 64'(uop_count_o), 64'(e_cnt));
    chk(req, "uops", 64'(uops_o), 64'(e_uops));
    chk("R4", "decode_en", 64'(decode_en_o), 64'(!m_shut));

    di      = da % SETS;
    ii      = ia % SETS;
    fill_ok = dv && (dc >= 1) && (dc <= SLOTS);
    kill    = iv && ((fill_ok && di == ii) || (m_v[ii] && m_tag[ii] == ia / SETS));
    if (fill_ok) begin
      m_v[di]   = 1'b1;
      m_tag[di] = da / SETS;
      m_cnt[di] = dc;
      for (int k = 0; k < SLOTS; k++) m_u[di][k] = uop_val(da, k, gen);
    end
    if (kill) m_v[ii] = 1'b0;
    idle_inputs();
  endtask

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle_inputs();
    for (int s = 0; s < SETS; s++) begin
      m_v[s] = 1'b0; m_tag[s] = 0; m_cnt[s] = 0;
    end
    m_shut = 1'b0;
    lfsr   = 32'h1badf00d;
    rst_n  = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset resp_valid", 64'(resp_valid_o), 64'd0);
    chk("R1", "reset hit", 64'(hit_o), 64'd0);
    chk("R1", "reset decode_en", 64'(decode_en_o), 64'd1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "post-reset count", 64'(uop_count_o), 64'd0);
    chk("R1", "post-reset uops", 64'(uops_o), 64'd0);
    chk("R1", "post-reset decode_en", 64'(decode_en_o), 64'd1);

    // R1: empty cache, every address misses.
    for (int a = 0; a < NADDR; a++) step(1, a, 0, 0, 0, 0, 0, 0, "R1");

    // R5/R6/R7: blind fill of every address with counts 0..6, then lookups.
    for (int a = 0; a < NADDR; a++) begin
      int dc = a % 7;
      step(0, 0, 1, a, dc, 1, 0, 0, "R5");
      step(1, a, 0, 0, 0, 0, 0, 0, (dc >= 1 && dc <= SLOTS) ? "R5" : "R6");
      if (a >= SETS) step(1, a - SETS, 0, 0, 0, 0, 0, 0, "R7");
    end

    // R10: lookup in the same cycle as a fill of its set, then after it.
    for (int a = 0; a < NADDR; a++) begin
      step(1, a, 1, a, (a % SLOTS) + 1, 2, 0, 0, "R10");
      step(1, a, 0, 0, 0, 0, 0, 0, "R10");
    end

    // R8: sweep evictions; only the resident tag kills a line.
    for (int a = 0; a < NADDR; a++) begin
      step(0, 0, 0, 0, 0, 0, 1, a, "R8");
      step(1, NADDR - SETS + (a % SETS), 0, 0, 0, 0, 0, 0, "R8");
    end

    // R9: fill and a non-matching eviction of the same set collide.
    for (int s = 0; s < SETS; s++) begin
      step(0, 0, 1, s + SETS, 2, 3, 1, s + 10 * SETS, "R9");
      step(1, s + SETS, 0, 0, 0, 0, 0, 0, "R9");
      step(0, 0, 1, s + SETS, 3, 4, 1, ((s + 1) % SETS) + 9 * SETS, "R9");
      step(1, s + SETS, 0, 0, 0, 0, 0, 0, "R9");
      // R10: eviction in the same cycle as a lookup of the line.
      step(1, s + SETS, 0, 0, 0, 0, 1, s + SETS, "R10");
      step(1, s + SETS, 0, 0, 0, 0, 0, 0, "R8");
    end

    // R3/R4: mixed traffic on a narrow address range for frequent hits.
    for (int n = 0; n < 4000; n++) begin
      lfsr = xs(lfsr);
      step(lfsr[0], int'(lfsr[5:1]) % 16,
           lfsr[6] & lfsr[7], int'(lfsr[12:8]) % 16, int'(lfsr[15:13]) % 7, n,
           lfsr[16] & lfsr[17] & lfsr[18], int'(lfsr[23:19]) % 16, "R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule